// File: doc/BRIEF.md
# TLB Exception Entry Unit

This unit performs the coprocessor-0 side of taking a translation fault. When the memory-management unit raises a fault request, the unit records the offending virtual address and the current address-space ID. It fills the translation-fault fields of the entry-high and context registers and writes the exception code. It captures the return PC and raises the exception level, and it redirects the fetch stream to the handler address derived from the exception base.

Refill faults taken at exception level 0 go to the dedicated refill vector at the exception base. A refill taken while already at exception level 1 goes to the general vector at base + 0x180. Invalid-entry and modified faults always take the general vector. The vector choice uses the exception level as it stood before the entry. A return-from-exception input clears the exception level. The PTE base field of the context register is written through its own write port.

Top module: `tlb_exc_entry`

## Requirements
- R1: After reset, every register output, `exl_o`, `redirect_valid_o` and `redirect_pc_o` read 0.
- R2: On an accepted fault, `badvaddr_o` takes the full 32-bit faulting address.
- R3: On a fault, `entryhi_o` becomes {va[31:13], va[12:11], 3'b000, asid[7:0]}.
- R4: On a fault, `context_o[22:4]` becomes va[31:13]. `context_o[3:0]` stays 0, and `context_o[31:23]` keeps the value last written through `ptebase_we_i`/`ptebase_i`.
- R5: `cause_exc_o` becomes 3 for a store and 2 for a load or fetch on refill (`fault_kind_i`=00) and invalid (01) faults, and 1 for modified faults (1x).
- R6: A refill fault redirects to `ebase_i` when `exl_o` was 0, and to `ebase_i`+0x180 when `exl_o` was already 1.
- R7: Invalid and modified faults always redirect to `ebase_i`+0x180.
- R8: A fault taken with `exl_o`=0 sets `epc_o` to `fault_pc_i`, or to `fault_pc_i`-4 with `cause_bd_o`=1 when `fault_dslot_i`=1. Otherwise `cause_bd_o` becomes 0.
- R9: A fault taken with `exl_o`=1 leaves `epc_o` and `cause_bd_o` unchanged.
- R10: All register updates and the redirect become visible in the cycle after the accepting edge, and `redirect_valid_o` is high for that one cycle only.
- R11: A fault sets `exl_o` to 1 and `eret_i` alone clears it. When both arrive in one cycle the fault wins, with the vector chosen from the pre-entry `exl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_valid_i | input | 1 | Translation fault request |
| fault_kind_i | input | 2 | 00 refill, 01 invalid, 1x modified |
| fault_store_i | input | 1 | Faulting access is a store |
| fault_vaddr_i | input | 32 | Faulting virtual address |
| fault_pc_i | input | 32 | PC of the faulting instruction |
| fault_dslot_i | input | 1 | Faulting instruction sits in a branch delay slot |
| asid_i | input | 8 | Current address-space ID |
| ebase_i | input | 32 | Exception base address |
| eret_i | input | 1 | Return from exception, clears exception level |
| ptebase_we_i | input | 1 | Write strobe for the context PTE base field |
| ptebase_i | input | 9 | PTE base value |
| redirect_valid_o | output | 1 | One-cycle handler redirect pulse |
| redirect_pc_o | output | 32 | Handler address |
| badvaddr_o | output | 32 | Bad virtual address register |
| entryhi_o | output | 32 | Entry-high register |
| context_o | output | 32 | Context register |
| cause_exc_o | output | 5 | Exception code |
| cause_bd_o | output | 1 | Branch-delay flag |
| exl_o | output | 1 | Exception level |
| epc_o | output | 32 | Exception return PC |

## Verification
The contended cycle is a fault request arriving together with a return-from-exception while the exception level is already 1. The fault must win, and its vector must come from the level before entry. The bench provokes it by raising `eret_i` and a refill `fault_valid_i` on the same edge. It then expects the general vector, an unchanged `epc_o`, and `exl_o` still at 1 in the following cycles. Nested faults with no return in between separately show that the pre-entry level steers both the vector and the EPC capture.

// File: rtl/tlb_exc_pkg.sv
package tlb_exc_pkg;
  typedef enum logic [1:0] {
    FK_REFILL  = 2'b00,
    FK_INVALID = 2'b01,
    FK_MOD     = 2'b10,
    FK_MOD_ALT = 2'b11
  } fault_kind_e;

  localparam logic [4:0] EXC_MOD   = 5'd1;
  localparam logic [4:0] EXC_LOAD  = 5'd2;
  localparam logic [4:0] EXC_STORE = 5'd3;
endpackage

// File: rtl/tlb_vec_sel.sv
module tlb_vec_sel
  import tlb_exc_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned GEN_OFS = 32'h180
) (
  input  logic [1:0]      kind_i,
  input  logic            exl_i,
  input  logic [VA_W-1:0] ebase_i,
  output logic [VA_W-1:0] vec_o
);
  fault_kind_e kind;
  assign kind = fault_kind_e'(kind_i);

  // pre-entry EXL picks refill vs general vector
  always_comb begin
    if (kind == FK_REFILL && !exl_i) vec_o = ebase_i;
    else                             vec_o = ebase_i + VA_W'(GEN_OFS);
  end
endmodule

// File: rtl/tlb_cp0_regs.sv
module tlb_cp0_regs
  import tlb_exc_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned ASID_W     = 8,
  parameter int unsigned PAIR_SHIFT = 13,
  localparam int unsigned VPN_W     = VA_W - PAIR_SHIFT,
  localparam int unsigned PTE_W     = VA_W - 4 - VPN_W,
  localparam int unsigned EHI_PAD   = PAIR_SHIFT - 2 - ASID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_valid_i,
  input  logic [1:0]        kind_i,
  input  logic              store_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [VA_W-1:0]   pc_i,
  input  logic              dslot_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              eret_i,
  input  logic              pte_we_i,
  input  logic [PTE_W-1:0]  pte_i,
  output logic [VA_W-1:0]   badvaddr_o,
  output logic [VA_W-1:0]   entryhi_o,
  output logic [VA_W-1:0]   context_o,
  output logic [4:0]        exc_o,
  output logic              bd_o,
  output logic              exl_o,
  output logic [VA_W-1:0]   epc_o
);
  logic [VA_W-1:0]   badv_q, epc_q;
  logic [VPN_W-1:0]  ehi_vpn_q, ctx_vpn_q;
  logic [1:0]        ehi_x_q;
  logic [ASID_W-1:0] asid_q;
  logic [PTE_W-1:0]  pte_q;
  logic [4:0]        exc_q, exc_d;
  logic              bd_q, exl_q;

  always_comb begin
    if (kind_i[1])    exc_d = EXC_MOD;
    else if (store_i) exc_d = EXC_STORE;
    else              exc_d = EXC_LOAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      badv_q    <= '0;
      epc_q     <= '0;
      ehi_vpn_q <= '0;
      ctx_vpn_q <= '0;
      ehi_x_q   <= '0;
      asid_q    <= '0;
      pte_q     <= '0;
      exc_q     <= '0;
      bd_q      <= 1'b0;
      exl_q     <= 1'b0;
    end else begin
      if (pte_we_i) pte_q <= pte_i;
      if (fault_valid_i) begin
        badv_q    <= vaddr_i;
        ehi_vpn_q <= vaddr_i[VA_W-1:PAIR_SHIFT];
        ehi_x_q   <= vaddr_i[PAIR_SHIFT-1:PAIR_SHIFT-2];
        asid_q    <= asid_i;
        ctx_vpn_q <= vaddr_i[VA_W-1:PAIR_SHIFT];
        exc_q     <= exc_d;
        exl_q     <= 1'b1;
        if (!exl_q) begin
          epc_q <= dslot_i ? pc_i - VA_W'(4) : pc_i;
          bd_q  <= dslot_i;
        end
      end else if (eret_i) begin
        exl_q <= 1'b0;
      end
    end
  end

  assign badvaddr_o = badv_q;
  assign entryhi_o  = {ehi_vpn_q, ehi_x_q, {EHI_PAD{1'b0}}, asid_q};
  assign context_o  = {pte_q, ctx_vpn_q, 4'b0000};
  assign exc_o      = exc_q;
  assign bd_o       = bd_q;
  assign exl_o      = exl_q;
  assign epc_o      = epc_q;

  AST_EXL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_i |=> exl_q); // R11
  AST_NESTED_EPC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_i && exl_q) |=> ($stable(epc_q) && $stable(bd_q))); // R9
  AST_BADVADDR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_i |=> (badvaddr_o == $past(vaddr_i))); // R2
  AST_PTE_BASE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pte_we_i |=> $stable(context_o[VA_W-1:VA_W-PTE_W])); // R4
endmodule

// File: rtl/tlb_exc_entry.sv
module tlb_exc_entry
  import tlb_exc_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned ASID_W     = 8,
  parameter int unsigned PAIR_SHIFT = 13,
  parameter int unsigned GEN_OFS    = 32'h180,
  localparam int unsigned PTE_W     = PAIR_SHIFT - 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_valid_i,
  input  logic [1:0]        fault_kind_i,
  input  logic              fault_store_i,
  input  logic [VA_W-1:0]   fault_vaddr_i,
  input  logic [VA_W-1:0]   fault_pc_i,
  input  logic              fault_dslot_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VA_W-1:0]   ebase_i,
  input  logic              eret_i,
  input  logic              ptebase_we_i,
  input  logic [PTE_W-1:0]  ptebase_i,
  output logic              redirect_valid_o,
  output logic [VA_W-1:0]   redirect_pc_o,
  output logic [VA_W-1:0]   badvaddr_o,
  output logic [VA_W-1:0]   entryhi_o,
  output logic [VA_W-1:0]   context_o,
  output logic [4:0]        cause_exc_o,
  output logic              cause_bd_o,
  output logic              exl_o,
  output logic [VA_W-1:0]   epc_o
);
  logic [VA_W-1:0] vec;
  logic            exl;

  tlb_vec_sel #(.VA_W(VA_W), .GEN_OFS(GEN_OFS)) u_vec (
    .kind_i  (fault_kind_i),
    .exl_i   (exl),
    .ebase_i (ebase_i),
    .vec_o   (vec)
  );

  tlb_cp0_regs #(.VA_W(VA_W), .ASID_W(ASID_W), .PAIR_SHIFT(PAIR_SHIFT)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fault_valid_i (fault_valid_i),
    .kind_i        (fault_kind_i),
    .store_i       (fault_store_i),
    .vaddr_i       (fault_vaddr_i),
    .pc_i          (fault_pc_i),
    .dslot_i       (fault_dslot_i),
    .asid_i        (asid_i),
    .eret_i        (eret_i),
    .pte_we_i      (ptebase_we_i),
    .pte_i         (ptebase_i),
    .badvaddr_o    (badvaddr_o),
    .entryhi_o     (entryhi_o),
    .context_o     (context_o),
    .exc_o         (cause_exc_o),
    .bd_o          (cause_bd_o),
    .exl_o         (exl),
    .epc_o         (epc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
    end else begin
      redirect_valid_o <= fault_valid_i;
      if (fault_valid_i) redirect_pc_o <= vec;
    end
  end

  assign exl_o = exl;

  AST_REFILL_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_i && fault_kind_i == 2'b00 && !exl) |=>
    (redirect_pc_o == $past(ebase_i))); // R6
  AST_GENERAL_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_i && (fault_kind_i != 2'b00 || exl)) |=>
    (redirect_pc_o == $past(ebase_i) + VA_W'(GEN_OFS))); // R7
  AST_REDIRECT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_valid_i |=> (redirect_valid_o && exl)); // R10
  AST_NO_SPURIOUS_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_valid_i |=> !redirect_valid_o); // R10
endmodule

// File: tb/tlb_exc_entry_bench.sv
`timescale 1ns/1ps
module tlb_exc_entry_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_valid = 1'b0;
  logic [1:0]  fault_kind = '0;
  logic        fault_store = 1'b0;
  logic [31:0] fault_vaddr = '0;
  logic [31:0] fault_pc = '0;
  logic        fault_dslot = 1'b0;
  logic [7:0]  asid = '0;
  logic [31:0] ebase = '0;
  logic        eret = 1'b0;
  logic        pte_we = 1'b0;
  logic [8:0]  pte = '0;
  logic        redirect_valid;
  logic [31:0] redirect_pc, badvaddr, entryhi, context_r, epc;
  logic [4:0]  cause_exc;
  logic        cause_bd, exl;

  always #4 clk = ~clk;

  tlb_exc_entry u_tlb_exc_entry (
    .clk_i(clk), .rst_ni(rst_n),
    .fault_valid_i(fault_valid), .fault_kind_i(fault_kind), .fault_store_i(fault_store),
    .fault_vaddr_i(fault_vaddr), .fault_pc_i(fault_pc), .fault_dslot_i(fault_dslot),
    .asid_i(asid), .ebase_i(ebase), .eret_i(eret),
    .ptebase_we_i(pte_we), .ptebase_i(pte),
    .redirect_valid_o(redirect_valid), .redirect_pc_o(redirect_pc),
    .badvaddr_o(badvaddr), .entryhi_o(entryhi), .context_o(context_r),
    .cause_exc_o(cause_exc), .cause_bd_o(cause_bd), .exl_o(exl), .epc_o(epc)
  );

  typedef struct packed {
    logic [31:0] vec, badv, ehi, ctx, epc;
    logic [4:0]  exc;
    logic        bd, refill, first;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  logic m_exl = 1'b0, m_bd = 1'b0;
  logic [31:0] m_epc = '0;
  logic [8:0]  m_pte = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per redirect pulse
  always @(negedge clk) begin
    if (rst_n && redirect_valid) begin
      if (q.size() == 0) chk("R10", "unexpected redirect", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.refill ? "R6" : "R7", "redirect_pc", redirect_pc, e.vec);
        chk("R2", "badvaddr", badvaddr, e.badv);
        chk("R3", "entryhi", entryhi, e.ehi);
        chk("R4", "context", context_r, e.ctx);
        chk("R5", "cause_exc", {27'd0, cause_exc}, {27'd0, e.exc});
        chk(e.first ? "R8" : "R9", "epc", epc, e.epc);
        chk(e.first ? "R8" : "R9", "cause_bd", {31'd0, cause_bd}, {31'd0, e.bd});
      end
    end
  end

  task automatic do_fault(input logic [1:0] k, input logic st, input logic [31:0] va,
                          input logic [31:0] pc, input logic ds, input logic [7:0] id,
                          input logic [31:0] eb, input logic rt);
    exp_t e;
    @(negedge clk);
    fault_valid = 1'b1; fault_kind = k; fault_store = st; fault_vaddr = va;
    fault_pc = pc; fault_dslot = ds; asid = id; ebase = eb; eret = rt;
    e.refill = (k == 2'b00);
    e.first  = !m_exl;
    e.vec    = (k == 2'b00 && !m_exl) ? eb : eb + 32'h180;
    e.exc    = k[1] ? 5'd1 : (st ? 5'd3 : 5'd2);
    if (!m_exl) begin
      m_epc = ds ? pc - 32'd4 : pc;
      m_bd  = ds;
    end
    m_exl  = 1'b1;
    e.badv = va;
    e.ehi  = {va[31:11], 3'b000, id};
    e.ctx  = {m_pte, va[31:13], 4'b0000};
    e.epc  = m_epc;
    e.bd   = m_bd;
    q.push_back(e);
    @(negedge clk);
    fault_valid = 1'b0; eret = 1'b0;
    @(negedge clk);
    chk("R10", "redirect pulse width", {31'd0, redirect_valid}, 32'd0);
    chk("R11", "exl after fault", {31'd0, exl}, 32'd1);
  endtask

  task automatic do_eret();
    @(negedge clk); eret = 1'b1;
    @(negedge clk); eret = 1'b0;
    m_exl = 1'b0;
    chk("R11", "exl after eret", {31'd0, exl}, 32'd0);
  endtask

  task automatic do_pte(input logic [8:0] v);
    @(negedge clk); pte_we = 1'b1; pte = v;
    @(negedge clk); pte_we = 1'b0;
    m_pte = v;
    chk("R4", "pte base write", {23'd0, context_r[31:23]}, {23'd0, v});
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset redirect_valid", {31'd0, redirect_valid}, 32'd0);
    chk("R1", "reset redirect_pc", redirect_pc, 32'd0);
    chk("R1", "reset exl", {31'd0, exl}, 32'd0);
    chk("R1", "reset epc", epc, 32'd0);
    chk("R1", "reset context", context_r, 32'd0);
    chk("R1", "reset entryhi", entryhi, 32'd0);
    rst_n = 1'b1;
    // first-level refill, load
    do_fault(2'b00, 1'b0, 32'h1234_5678, 32'h8000_0100, 1'b0, 8'h3c, 32'h8000_0000, 1'b0);
    do_eret();
    // first-level refill, store in delay slot
    do_fault(2'b00, 1'b1, 32'hdead_beef, 32'h8000_0200, 1'b1, 8'ha5, 32'h9000_0000, 1'b0);
    // nested invalid: EPC and BD kept
    do_fault(2'b01, 1'b0, 32'h0000_2800, 32'h1111_1110, 1'b0, 8'h01, 32'h9000_0000, 1'b0);
    // nested refill, store: general vector
    do_fault(2'b00, 1'b1, 32'hffff_f000, 32'h2222_2220, 1'b1, 8'hff, 32'ha000_0000, 1'b0);
    do_eret();
    // modified fault, both encodings
    do_fault(2'b10, 1'b1, 32'h4000_1800, 32'h3333_3330, 1'b0, 8'h42, 32'h8000_0000, 1'b0);
    do_eret();
    do_fault(2'b11, 1'b1, 32'h0abc_d000, 32'h3333_4440, 1'b1, 8'h43, 32'h8000_1000, 1'b0);
    do_eret();
    do_pte(9'h1a5);
    // invalid store with PTE base preserved
    do_fault(2'b01, 1'b1, 32'h7654_3210, 32'h4444_4440, 1'b0, 8'h77, 32'hbfc0_0000, 1'b0);
    // fault and eret together at EXL=1: fault wins
    do_fault(2'b00, 1'b0, 32'h0102_0304, 32'h5555_5550, 1'b0, 8'h09, 32'hbfc0_0000, 1'b1);
    chk("R11", "exl held after fault+eret", {31'd0, exl}, 32'd1);
    do_eret();
    // refill at EXL=0 after return: dedicated vector again
    do_fault(2'b00, 1'b0, 32'h00ff_e000, 32'h6666_6660, 1'b0, 8'h10, 32'h8000_0000, 1'b0);
    repeat (2) @(negedge clk);
    chk("R10", "scoreboard drained", q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule